// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block gathers interrupt request flags from the peripherals of a small processor, gates each of them according to the maskability class of its priority level, and picks one winner by fixed priority. It has sixteen levels. Level 15 is the reset vector and cannot be blocked. Level 14 carries the non-maskable group, which obeys only its per-flag enables. Levels 13 to 1 are ordinary maskable lines and need both a per-flag enable and the global enable. Level 0 has no source. The winner's level number and the 16-bit address of its vector word are registered and held while the pending output is high.

The processor answers a pending request with a one-cycle acknowledge. The acknowledge drops the pending output and clears the global enable. When the serviced level has exactly one source flag, the controller also pulses a clear strobe for that level so that the peripheral can drop the flag. Multi-flag levels are left for software to clear. The global enable is a register inside the block that is loaded through a write strobe.

Top module: `ivc_vector_ctrl`

## Requirements
- R1: After reset, `irq_pend` is 0, `irq_idx` is 0, `vec_addr` is 16'hFFE0, `gie` is 0 and `svc_clr` is all zero.
- R2: When several levels are eligible, the highest-numbered one is captured into `irq_idx` on the clock edge after pending was low.
- R3: `vec_addr` equals 16'hFFE0 + 2 × `irq_idx`, so level 15 gives 16'hFFFE and level 1 gives 16'hFFE2.
- R4: `reset_req` makes level 15 eligible whatever the values of `gie`, `nmi_en` and `mask_en`.
- R5: Bit i of `nmi_flag` makes level 14 eligible only when bit i of `nmi_en` is set, and `gie` has no effect on it.
- R6: A flag of levels 1 to 13 is eligible only when its `mask_en` bit and `gie` are both 1. With the defaults, `mask_flag` holds level 1 in bits 0–7, level 2 in bit 8, level 3 in bit 9, level 4 in bits 10–17, level 5 in bits 18–20, level 6 in bit 21, level 7 in bits 22–25, levels 8, 9, 10 and 11 in bits 26, 27, 28 and 29, level 12 in bits 30–36 and level 13 in bit 37.
- R7: A level with several flags is requested when any one of its enabled flags is set.
- R8: Level 0 is never requested. With no eligible request, `irq_pend` stays 0.
- R9: Parameter `TB_SEVEN` sets the width of the level-12 group: seven flags when 1 (the default), three flags when 0. The positions of the higher levels move to match.
- R10: While `irq_pend` is high and `ack` is low, `irq_idx` and `vec_addr` hold their values even if a higher level becomes eligible.
- R11: `ack` while pending clears `irq_pend` and `gie` on the next edge. `ack` while not pending changes nothing.
- R12: During an accepted `ack`, `svc_clr` has exactly the bit of the serviced level set when that level has a single flag (levels 2, 3, 6, 8, 9, 10, 11, 13 with the defaults). It is zero for multi-flag levels and at all other times.
- R13: `gie_wr` loads `gie_wdata` into `gie`. An accepted `ack` in the same cycle wins and leaves `gie` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reset_req | input | 1 | Combined reset-class request (level 15) |
| nmi_flag | input | NMI_N | Non-maskable group flags (level 14) |
| nmi_en | input | NMI_N | Per-flag enables for level 14 |
| mask_flag | input | NMF | Maskable flags of levels 1 to 13, packed from level 1 upward |
| mask_en | input | NMF | Per-flag enables for `mask_flag` |
| gie_wr | input | 1 | Write strobe for the global enable |
| gie_wdata | input | 1 | Value written to the global enable |
| ack | input | 1 | One-cycle acknowledge from the processor |
| irq_pend | output | 1 | A captured request waits for service |
| irq_idx | output | 4 | Captured priority level |
| vec_addr | output | 16 | Address of the vector word for `irq_idx` |
| gie | output | 1 | Current global enable |
| svc_clr | output | 16 | One-hot clear strobe per level for single-flag levels |

## Verification
A table drives single flags, pairs of flags on different levels, flags with their individual enable off, and the same flags with the global enable off. The pairs show that the higher level wins, and the masked cases show which class ignores which enable. The last flag of the level-12 group and a high flag of the level-7 group show that the OR of each group and the packed bit layout are right. Directed tests cover the hold of a captured request against a later higher request, the clear strobe for single-flag and multi-flag levels, an acknowledge with nothing pending, and a global-enable write that lands in the same cycle as an acknowledge.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

  localparam int NLVL = 16;

  // Number of maskable flags feeding a level (levels 1..13 only).
  function automatic int grp_width(input int lvl, input bit tb7, input int adc_n);
    case (lvl)
      12:      return tb7 ? 7 : 3;
      7:       return adc_n;
      5:       return 3;
      4, 1:    return 8;
      default: return (lvl >= 2 && lvl <= 13) ? 1 : 0;
    endcase
  endfunction

  // Bit position of a level's first flag inside the packed maskable vector.
  function automatic int grp_base(input int lvl, input bit tb7, input int adc_n);
    int sum;
    sum = 0;
    for (int l = 1; l < lvl; l++) sum += grp_width(l, tb7, adc_n);
    return sum;
  endfunction

  function automatic int flag_total(input bit tb7, input int adc_n);
    return grp_base(14, tb7, adc_n);
  endfunction

  function automatic bit single_src(input int lvl, input bit tb7, input int adc_n);
    return (lvl >= 1 && lvl <= 13) && (grp_width(lvl, tb7, adc_n) == 1);
  endfunction

  function automatic logic [15:0] vec_of(input logic [3:0] idx);
    return 16'hFFE0 + {11'd0, idx, 1'b0};
  endfunction

endpackage

// File: rtl/ivc_level_gate.sv
module ivc_level_gate #(
  parameter bit TB_SEVEN  = 1'b1,
  parameter int ADC_FLAGS = 4,
  parameter int NMI_N     = 3,
  parameter int NMF       = ivc_pkg::flag_total(TB_SEVEN, ADC_FLAGS)
) (
  input  logic             reset_req,
  input  logic [NMI_N-1:0] nmi_flag,
  input  logic [NMI_N-1:0] nmi_en,
  input  logic             gie,
  input  logic [NMF-1:0]   mask_flag,
  input  logic [NMF-1:0]   mask_en,
  output logic [15:0]      lvl_req
);
  assign lvl_req[0]  = 1'b0;
  assign lvl_req[14] = |(nmi_flag & nmi_en);
  assign lvl_req[15] = reset_req;

  for (genvar g = 1; g <= 13; g++) begin : g_lvl
    localparam int W = ivc_pkg::grp_width(g, TB_SEVEN, ADC_FLAGS);
    localparam int B = ivc_pkg::grp_base(g, TB_SEVEN, ADC_FLAGS);
    assign lvl_req[g] = gie & (|(mask_flag[B +: W] & mask_en[B +: W]));
  end
endmodule

// File: rtl/ivc_prio_enc.sv
module ivc_prio_enc (
  input  logic [15:0] req,
  output logic        any,
  output logic [3:0]  idx,
  output logic [15:0] win_oh
);
  always_comb begin
    idx = 4'd0;
    for (int i = 0; i < 16; i++) begin
      if (req[i]) idx = 4'(i);
    end
    any    = |req;
    win_oh = any ? (16'd1 << idx) : 16'd0;
  end
endmodule

// File: rtl/ivc_gie_reg.sv
module ivc_gie_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wdata,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (clr) q <= 1'b0;
    else if (wr)  q <= wdata;
  end
endmodule

// File: rtl/ivc_vector_ctrl.sv
module ivc_vector_ctrl #(
  parameter bit TB_SEVEN  = 1'b1,
  parameter int ADC_FLAGS = 4,
  parameter int NMI_N     = 3,
  localparam int NMF      = ivc_pkg::flag_total(TB_SEVEN, ADC_FLAGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reset_req,
  input  logic [NMI_N-1:0] nmi_flag,
  input  logic [NMI_N-1:0] nmi_en,
  input  logic [NMF-1:0]   mask_flag,
  input  logic [NMF-1:0]   mask_en,
  input  logic             gie_wr,
  input  logic             gie_wdata,
  input  logic             ack,
  output logic             irq_pend,
  output logic [3:0]       irq_idx,
  output logic [15:0]      vec_addr,
  output logic             gie,
  output logic [15:0]      svc_clr
);
  logic [15:0] lvl_req;
  logic [15:0] win_oh;
  logic [3:0]  win_idx;
  logic        any_req;
  logic        ack_take;
  logic        pend_q;
  logic [3:0]  idx_q;

  assign ack_take = ack & pend_q;

  ivc_gie_reg u_gie (
    .clk(clk), .rst_n(rst_n), .wr(gie_wr), .wdata(gie_wdata),
    .clr(ack_take), .q(gie)
  );

  ivc_level_gate #(
    .TB_SEVEN(TB_SEVEN), .ADC_FLAGS(ADC_FLAGS), .NMI_N(NMI_N), .NMF(NMF)
  ) u_gate (
    .reset_req(reset_req), .nmi_flag(nmi_flag), .nmi_en(nmi_en), .gie(gie),
    .mask_flag(mask_flag), .mask_en(mask_en), .lvl_req(lvl_req)
  );

  ivc_prio_enc u_enc (
    .req(lvl_req), .any(any_req), .idx(win_idx), .win_oh(win_oh)
  );

  // Capture the winner once; hold it until the acknowledge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      idx_q  <= 4'd0;
    end else if (pend_q) begin
      if (ack) pend_q <= 1'b0;
    end else if (any_req) begin
      pend_q <= 1'b1;
      idx_q  <= win_idx;
    end
  end

  for (genvar l = 0; l < 16; l++) begin : g_clr
    localparam bit SINGLE = ivc_pkg::single_src(l, TB_SEVEN, ADC_FLAGS);
    assign svc_clr[l] = SINGLE && ack_take && (idx_q == 4'(l));
  end

  assign irq_pend = pend_q;
  assign irq_idx  = idx_q;
  assign vec_addr = ivc_pkg::vec_of(idx_q);

  assert_win_in_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_oh) && ((win_oh & ~lvl_req) == 16'd0));

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q && any_req |=> pend_q && (idx_q == $past(win_idx)));

  assert_reset_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q && reset_req |=> pend_q && (idx_q == 4'd15));

  assert_no_level0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (idx_q != 4'd0));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !ack |=> pend_q && $stable(idx_q));

  assert_ack_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ack && pend_q |=> !pend_q && !gie);

  assert_idle_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ack && !pend_q && !gie_wr |=> $stable(gie));

  assert_svc_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(svc_clr) && ((svc_clr == 16'd0) || (ack && pend_q)));
endmodule

// File: tb/ivc_vector_ctrl_bench.sv
module ivc_vector_ctrl_bench;
  localparam int NMF = 38;

  typedef struct packed {
    logic           rst;
    logic [2:0]     nf;
    logic [2:0]     ne;
    logic           g;
    logic [NMF-1:0] mf;
    logic [NMF-1:0] me;
    logic           ep;
    logic [3:0]     ei;
  } vec_t;

  localparam logic [NMF-1:0] ONE = 38'd1;

  localparam vec_t TBL [11] = '{
    // R8: nothing eligible
    '{1'b0, 3'b000, 3'b000, 1'b1, 38'd0, 38'd0, 1'b0, 4'd0},
    // R6: level 1 flag, enabled, gie on
    '{1'b0, 3'b000, 3'b000, 1'b1, ONE << 3, ONE << 3, 1'b1, 4'd1},
    // R6: same with gie off
    '{1'b0, 3'b000, 3'b000, 1'b0, ONE << 3, ONE << 3, 1'b0, 4'd0},
    // R6: same with its enable off
    '{1'b0, 3'b000, 3'b000, 1'b1, ONE << 3, 38'd0, 1'b0, 4'd0},
    // R2/R7/R9: last flag of level 12 against level 4
    '{1'b0, 3'b000, 3'b000, 1'b1, (ONE << 36) | (ONE << 12), (ONE << 36) | (ONE << 12), 1'b1, 4'd12},
    // R2/R5: level 14 beats level 13
    '{1'b0, 3'b010, 3'b010, 1'b1, ONE << 37, ONE << 37, 1'b1, 4'd14},
    // R5: level 14 with gie off
    '{1'b0, 3'b001, 3'b001, 1'b0, 38'd0, 38'd0, 1'b1, 4'd14},
    // R5: level 14 flag without its enable, maskable blocked by gie
    '{1'b0, 3'b100, 3'b011, 1'b0, ONE << 9, ONE << 9, 1'b0, 4'd0},
    // R4: reset request, all enables off
    '{1'b1, 3'b111, 3'b000, 1'b0, {NMF{1'b1}}, 38'd0, 1'b1, 4'd15},
    // R7: high flag of level 7 beats level 5
    '{1'b0, 3'b000, 3'b000, 1'b1, (ONE << 25) | (ONE << 18), (ONE << 25) | (ONE << 18), 1'b1, 4'd7},
    // R2: level 11 beats level 2
    '{1'b0, 3'b000, 3'b000, 1'b1, (ONE << 29) | (ONE << 8), (ONE << 29) | (ONE << 8), 1'b1, 4'd11}
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           reset_req = 1'b0;
  logic [2:0]     nmi_flag = '0;
  logic [2:0]     nmi_en = '0;
  logic [NMF-1:0] mask_flag = '0;
  logic [NMF-1:0] mask_en = '0;
  logic           gie_wr = 1'b0;
  logic           gie_wdata = 1'b0;
  logic           ack = 1'b0;
  logic           irq_pend;
  logic [3:0]     irq_idx;
  logic [15:0]    vec_addr;
  logic           gie;
  logic [15:0]    svc_clr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ivc_vector_ctrl u_ivc_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .nmi_flag(nmi_flag),
    .nmi_en(nmi_en), .mask_flag(mask_flag), .mask_en(mask_en),
    .gie_wr(gie_wr), .gie_wdata(gie_wdata), .ack(ack),
    .irq_pend(irq_pend), .irq_idx(irq_idx), .vec_addr(vec_addr),
    .gie(gie), .svc_clr(svc_clr)
  );

  function automatic logic [15:0] addr_for(input logic [3:0] lvl);
    return 16'hFFE0 | (16'(lvl) * 16'd2);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_inputs();
    reset_req = 1'b0; nmi_flag = '0; nmi_en = '0;
    mask_flag = '0; mask_en = '0; gie_wr = 1'b0; ack = 1'b0;
  endtask

  task automatic write_gie(input logic v);
    @(negedge clk); gie_wr = 1'b1; gie_wdata = v;
    @(negedge clk); gie_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 pend", 32'(irq_pend), 0);
    check("R1 idx", 32'(irq_idx), 0);
    check("R1 vec", 32'(vec_addr), 32'hFFE0);
    check("R1 gie", 32'(gie), 0);
    check("R1 svc_clr", 32'(svc_clr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 pend after release", 32'(irq_pend), 0);

    // Table walk
    foreach (TBL[k]) begin
      write_gie(TBL[k].g);
      reset_req = TBL[k].rst; nmi_flag = TBL[k].nf; nmi_en = TBL[k].ne;
      mask_flag = TBL[k].mf; mask_en = TBL[k].me;
      @(negedge clk);
      check($sformatf("R2 row%0d pend", k), 32'(irq_pend), 32'(TBL[k].ep));
      if (TBL[k].ep) begin
        check($sformatf("R2 row%0d idx", k), 32'(irq_idx), 32'(TBL[k].ei));
        check($sformatf("R3 row%0d vec", k), 32'(vec_addr), 32'(addr_for(TBL[k].ei)));
      end
      clear_inputs();
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
      @(negedge clk);
      check($sformatf("R11 row%0d pend after ack", k), 32'(irq_pend), 0);
    end

    // R10: hold against a later higher request; R12 single-flag clear
    write_gie(1'b1);
    mask_flag = ONE << 9; mask_en = (ONE << 9) | (ONE << 37);
    @(negedge clk);
    check("R10 captured level 3", 32'(irq_idx), 3);
    mask_flag = (ONE << 9) | (ONE << 37);
    @(negedge clk);
    check("R10 idx held", 32'(irq_idx), 3);
    check("R10 vec held", 32'(vec_addr), 32'hFFE6);
    @(negedge clk);
    check("R10 pend held", 32'(irq_pend), 1);
    check("R12 no clear before ack", 32'(svc_clr), 0);
    ack = 1'b1;
    #1;
    check("R12 single-flag clear", 32'(svc_clr), 32'h0008);
    @(negedge clk);
    ack = 1'b0;
    check("R11 gie cleared by ack", 32'(gie), 0);
    check("R11 pend cleared by ack", 32'(irq_pend), 0);
    @(negedge clk);
    check("R6 no repend with gie cleared", 32'(irq_pend), 0);
    clear_inputs();

    // R12: multi-flag level gives no clear strobe
    write_gie(1'b1);
    mask_flag = ONE << 15; mask_en = ONE << 15;
    @(negedge clk);
    check("R7 level 4 pending", 32'(irq_idx), 4);
    mask_flag = '0;
    ack = 1'b1;
    #1;
    check("R12 multi-flag no clear", 32'(svc_clr), 0);
    @(negedge clk);
    ack = 1'b0;

    // R11: acknowledge with nothing pending leaves gie alone
    write_gie(1'b1);
    ack = 1'b1;
    #1;
    check("R12 no clear when idle", 32'(svc_clr), 0);
    @(negedge clk);
    ack = 1'b0;
    check("R11 idle ack keeps gie", 32'(gie), 1);
    check("R8 idle stays low", 32'(irq_pend), 0);

    // R13: write and acknowledge in the same cycle
    nmi_flag = 3'b100; nmi_en = 3'b100;
    @(negedge clk);
    check("R5 level 14 pending", 32'(irq_idx), 14);
    nmi_flag = '0; nmi_en = '0;
    ack = 1'b1; gie_wr = 1'b1; gie_wdata = 1'b1;
    #1;
    check("R12 level 14 no clear", 32'(svc_clr), 0);
    @(negedge clk);
    ack = 1'b0; gie_wr = 1'b0;
    check("R13 ack beats write", 32'(gie), 0);
    write_gie(1'b1);
    check("R13 write loads gie", 32'(gie), 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule